// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one channel of a DMA controller. Software programs it through an 8-bit register port. The port gives access to two control bytes, a source pointer, a destination pointer and a transfer count. The channel watches a set of request strobes, and one of them is selected by the control bytes. When the selected strobe fires, the channel latches a pending flag. While the channel is enabled, each pending request is serviced as one read from the source pointer followed by one write to the destination pointer, over a simple single-cycle memory port.

Each transfer moves either a halfword or a byte. Each pointer either stays put or steps forward by the transfer size. The count runs down by one per transfer. At the end of the count, normal mode switches the channel off. Ring mode restores the programmed pointers and count and keeps running. Both modes raise a one-cycle completion strobe at that point. Hardware event sources are outside the block and arrive as single-cycle strobes.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset every register reads 0x00, and `mem_rd_o`, `mem_wr_o` and `done_o` are low.
- R2: Control byte 0 is laid out as follows: bit 0 mode (1 = ring), bit 1 pending flag, bits 3:2 source select, bit 4 enable, bit 5 size (0 = 16-bit, 1 = 8-bit), bit 6 source step, bit 7 destination step. Control byte 1 holds the extended selector in bits 7:4. Its bits 3:0 read 0 and ignore writes.
- R3: Writing 0 to the pending flag clears it, and writing 1 leaves it unchanged. Only a request strobe can set the flag.
- R4: The source select chooses the request as follows: 00 = `sw_start_i`, 01 = `ser0_txe_i`, 10 = `ser1_rx_i`, 11 = `ext_evt_i[k]`, where k is the extended selector value in the range 0..9. A strobe from a source that is not selected leaves the flag unchanged.
- R5: Extended selector codes 10 to 15 never set the pending flag, even when every event strobe fires.
- R6: While the enable bit is 0, a pending request stays latched and no memory cycle is issued. Setting the enable bit later services that request.
- R7: Servicing a request clears the flag and issues one read cycle at the source pointer. This is followed by one write cycle at the destination pointer that carries the data read. In 8-bit size only the low byte is written.
- R8: A pointer whose step bit is 0 keeps its value. One whose step bit is 1 advances by 2 after a 16-bit transfer and by 1 after an 8-bit transfer.
- R9: Each transfer decrements the count. In normal mode the transfer that takes the count to zero clears the enable bit and raises `done_o` for one cycle. A programmed count of 0 means 2^CNT_W transfers.
- R10: In ring mode the transfer that ends the count reloads both pointers and the count with their programmed values. The enable bit stays 1 and `done_o` pulses.
- R11: The register offsets are: 0 control byte 0, 1 control byte 1, 2/3 source pointer low/high, 4/5 destination pointer low/high, 6/7 count low/high. A byte beyond the implemented width reads 0. Writing a pointer or count byte sets both the programmed and the working value. Reads return the working value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register byte offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational on offset) |
| sw_start_i | input | 1 | Software start strobe |
| ser0_txe_i | input | 1 | Serial port 0 transmit-empty strobe |
| ser1_rx_i | input | 1 | Serial port 1 receive strobe |
| ext_evt_i | input | EXT_N | Extended hardware event strobes |
| mem_rd_o | output | 1 | Memory read cycle |
| mem_wr_o | output | 1 | Memory write cycle |
| mem_byte_o | output | 1 | Transfer is 8-bit |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, valid in the read cycle |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The pointer-step and ring-reload assertions only hold when software does not write the pointer or count bytes in the same cycle as the final step of a transfer. They are therefore qualified on the absence of a register write. The assertions also take the memory as answering a read within the read cycle itself. The bench keeps to both conditions. Its memory model is combinational. It issues each request as a one-cycle strobe and then leaves the channel alone for six cycles, which covers the full four-edge path from strobe to write. It reprograms the channel only while it is disabled.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RD   = 2'd1,
    SEQ_WR   = 2'd2
  } seq_state_e;

  localparam logic [1:0] SRC_SW  = 2'd0;
  localparam logic [1:0] SRC_TX  = 2'd1;
  localparam logic [1:0] SRC_RX  = 2'd2;
  localparam logic [1:0] SRC_EXT = 2'd3;

  localparam logic [2:0] OFS_CTRL0 = 3'd0;
  localparam logic [2:0] OFS_CTRL1 = 3'd1;
  localparam logic [2:0] OFS_SRC_L = 3'd2;
  localparam logic [2:0] OFS_SRC_H = 3'd3;
  localparam logic [2:0] OFS_DST_L = 3'd4;
  localparam logic [2:0] OFS_DST_H = 3'd5;
  localparam logic [2:0] OFS_CNT_L = 3'd6;
  localparam logic [2:0] OFS_CNT_H = 3'd7;
endpackage

// File: rtl/dma_req_sel.sv
module dma_req_sel import dma_chan_pkg::*; #(
  parameter int EXT_N = 10
) (
  input  logic [1:0]       src_sel_i,
  input  logic [3:0]       ext_sel_i,
  input  logic             sw_start_i,
  input  logic             ser0_txe_i,
  input  logic             ser1_rx_i,
  input  logic [EXT_N-1:0] ext_evt_i,
  output logic             req_o
);
  logic [EXT_N-1:0] ext_match;
  logic             ext_hit;

  // codes at or above EXT_N match no lane, so reserved codes stay silent
  for (genvar k = 0; k < EXT_N; k++) begin : g_ext
    assign ext_match[k] = (ext_sel_i == 4'(k)) && ext_evt_i[k];
  end
  assign ext_hit = |ext_match;

  always_comb begin
    unique case (src_sel_i)
      SRC_SW:  req_o = sw_start_i;
      SRC_TX:  req_o = ser0_txe_i;
      SRC_RX:  req_o = ser1_rx_i;
      default: req_o = ext_hit;
    endcase
  end
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] cur_i,
  input  logic              inc_i,
  input  logic              byte_i,
  output logic [ADDR_W-1:0] next_o
);
  logic [ADDR_W-1:0] delta;

  assign delta  = !inc_i ? '0 : (byte_i ? ADDR_W'(1) : ADDR_W'(2));
  assign next_o = cur_i + delta;
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq import dma_chan_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  output logic take_o,
  output logic rd_o,
  output logic wr_o
);
  seq_state_e state_q, state_d;

  assign take_o = (state_q == SEQ_IDLE) && go_i;
  assign rd_o   = (state_q == SEQ_RD);
  assign wr_o   = (state_q == SEQ_WR);

  always_comb begin
    unique case (state_q)
      SEQ_IDLE: state_d = go_i ? SEQ_RD : SEQ_IDLE;
      SEQ_RD:   state_d = SEQ_WR;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end

  AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o)); // R7
  AST_WR_AFTER_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |=> wr_o); // R7
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl import dma_chan_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int EXT_N  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              sw_start_i,
  input  logic              ser0_txe_i,
  input  logic              ser1_rx_i,
  input  logic [EXT_N-1:0]  ext_evt_i,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              mem_byte_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [15:0]       mem_wdata_o,
  input  logic [15:0]       mem_rdata_i,
  output logic              done_o
);
  localparam int REG_W = 16;

  logic ring_q, flag_q, en_q, byte_q, src_inc_q, dst_inc_q;
  logic [1:0] src_sel_q;
  logic [3:0] ext_sel_q;
  logic [ADDR_W-1:0] src_base_q, src_cur_q, dst_base_q, dst_cur_q;
  logic [ADDR_W-1:0] src_next, dst_next, src_base_d, dst_base_d;
  logic [CNT_W-1:0]  cnt_base_q, cnt_cur_q, cnt_base_d;
  logic [REG_W-1:0]  src_w16, dst_w16, cnt_w16;
  logic [REG_W-1:0]  src_r16, dst_r16, cnt_r16;
  logic [15:0] data_q;
  logic done_q;

  logic wr_c0, wr_c1, wr_src, wr_dst, wr_cnt;
  logic req_hit, take, step, last, end_ev;

  assign wr_c0  = reg_we_i && (reg_addr_i == OFS_CTRL0);
  assign wr_c1  = reg_we_i && (reg_addr_i == OFS_CTRL1);
  assign wr_src = reg_we_i && (reg_addr_i == OFS_SRC_L || reg_addr_i == OFS_SRC_H);
  assign wr_dst = reg_we_i && (reg_addr_i == OFS_DST_L || reg_addr_i == OFS_DST_H);
  assign wr_cnt = reg_we_i && (reg_addr_i == OFS_CNT_L || reg_addr_i == OFS_CNT_H);

  dma_req_sel #(.EXT_N(EXT_N)) u_req_sel (
    .src_sel_i (src_sel_q),
    .ext_sel_i (ext_sel_q),
    .sw_start_i(sw_start_i),
    .ser0_txe_i(ser0_txe_i),
    .ser1_rx_i (ser1_rx_i),
    .ext_evt_i (ext_evt_i),
    .req_o     (req_hit)
  );

  dma_xfer_seq u_seq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .go_i  (en_q && flag_q),
    .take_o(take),
    .rd_o  (mem_rd_o),
    .wr_o  (step)
  );

  dma_addr_step #(.ADDR_W(ADDR_W)) u_src_step (
    .cur_i(src_cur_q), .inc_i(src_inc_q), .byte_i(byte_q), .next_o(src_next)
  );

  dma_addr_step #(.ADDR_W(ADDR_W)) u_dst_step (
    .cur_i(dst_cur_q), .inc_i(dst_inc_q), .byte_i(byte_q), .next_o(dst_next)
  );

  assign last   = (cnt_cur_q == CNT_W'(1));
  assign end_ev = step && last;

  // byte-lane merge of register writes into the programmed values
  assign src_r16 = REG_W'(src_base_q);
  assign dst_r16 = REG_W'(dst_base_q);
  assign cnt_r16 = REG_W'(cnt_base_q);

  always_comb begin
    src_w16 = src_r16;
    dst_w16 = dst_r16;
    cnt_w16 = cnt_r16;
    if (reg_addr_i[0]) begin
      src_w16[15:8] = reg_wdata_i;
      dst_w16[15:8] = reg_wdata_i;
      cnt_w16[15:8] = reg_wdata_i;
    end else begin
      src_w16[7:0] = reg_wdata_i;
      dst_w16[7:0] = reg_wdata_i;
      cnt_w16[7:0] = reg_wdata_i;
    end
  end

  assign src_base_d = ADDR_W'(src_w16);
  assign dst_base_d = ADDR_W'(dst_w16);
  assign cnt_base_d = CNT_W'(cnt_w16);

  // control byte 0 and 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ring_q    <= 1'b0;
      src_sel_q <= SRC_SW;
      en_q      <= 1'b0;
      byte_q    <= 1'b0;
      src_inc_q <= 1'b0;
      dst_inc_q <= 1'b0;
      ext_sel_q <= '0;
    end else begin
      if (wr_c0) begin
        ring_q    <= reg_wdata_i[0];
        src_sel_q <= reg_wdata_i[3:2];
        en_q      <= reg_wdata_i[4];
        byte_q    <= reg_wdata_i[5];
        src_inc_q <= reg_wdata_i[6];
        dst_inc_q <= reg_wdata_i[7];
      end
      if (end_ev && !ring_q) en_q <= 1'b0;  // end of count beats a software write
      if (wr_c1) ext_sel_q <= reg_wdata_i[7:4];
    end
  end

  // pending flag: service clear, software clear, then set wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (req_hit) begin
      flag_q <= 1'b1;
    end else if (take || (wr_c0 && !reg_wdata_i[1])) begin
      flag_q <= 1'b0;
    end
  end

  // pointers and count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_base_q <= '0;
      src_cur_q  <= '0;
      dst_base_q <= '0;
      dst_cur_q  <= '0;
      cnt_base_q <= '0;
      cnt_cur_q  <= '0;
    end else begin
      if (wr_src) begin
        src_base_q <= src_base_d;
        src_cur_q  <= src_base_d;
      end else if (step) begin
        src_cur_q  <= (end_ev && ring_q) ? src_base_q : src_next;
      end
      if (wr_dst) begin
        dst_base_q <= dst_base_d;
        dst_cur_q  <= dst_base_d;
      end else if (step) begin
        dst_cur_q  <= (end_ev && ring_q) ? dst_base_q : dst_next;
      end
      if (wr_cnt) begin
        cnt_base_q <= cnt_base_d;
        cnt_cur_q  <= cnt_base_d;
      end else if (step) begin
        cnt_cur_q  <= (end_ev && ring_q) ? cnt_base_q : cnt_cur_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (mem_rd_o) data_q <= mem_rdata_i;
      done_q <= end_ev;
    end
  end

  assign mem_wr_o    = step;
  assign mem_byte_o  = byte_q;
  assign mem_addr_o  = step ? dst_cur_q : src_cur_q;
  assign mem_wdata_o = data_q;
  assign done_o      = done_q;

  always_comb begin
    unique case (reg_addr_i)
      OFS_CTRL0: reg_rdata_o = {dst_inc_q, src_inc_q, byte_q, en_q, src_sel_q, flag_q, ring_q};
      OFS_CTRL1: reg_rdata_o = {ext_sel_q, 4'b0000};
      OFS_SRC_L: reg_rdata_o = REG_W'(src_cur_q) >> 0;
      OFS_SRC_H: reg_rdata_o = 8'(REG_W'(src_cur_q) >> 8);
      OFS_DST_L: reg_rdata_o = 8'(REG_W'(dst_cur_q));
      OFS_DST_H: reg_rdata_o = 8'(REG_W'(dst_cur_q) >> 8);
      OFS_CNT_L: reg_rdata_o = 8'(REG_W'(cnt_cur_q));
      default:   reg_rdata_o = 8'(REG_W'(cnt_cur_q) >> 8);
    endcase
  end

  AST_FLAG_ON_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_hit |=> flag_q); // R4
  AST_FLAG_ONLY_BY_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(req_hit)); // R3
  AST_FLAG_WRITE_ONE_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && wr_c0 && reg_wdata_i[1] && !take) |=> flag_q); // R3
  AST_RESERVED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && src_sel_q == SRC_EXT && ext_sel_q >= 4'(EXT_N)) |=> !flag_q); // R5
  AST_NO_READ_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_rd_o) |-> $past(en_q)); // R6
  AST_NORMAL_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_ev && !ring_q) |=> (!en_q && done_o)); // R9
  AST_RING_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_ev && ring_q && !reg_we_i) |=> (en_q && done_o && cnt_cur_q == $past(cnt_base_q))); // R10
  AST_SRC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && src_inc_q && !reg_we_i && !(end_ev && ring_q))
      |=> src_cur_q == $past(src_cur_q) + ($past(byte_q) ? ADDR_W'(1) : ADDR_W'(2))); // R8
  AST_DST_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !dst_inc_q && !reg_we_i && !(end_ev && ring_q)) |=> $stable(dst_cur_q)); // R8
endmodule

// File: tb/dma_chan_ctrl_test.sv
module dma_chan_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 8;
  localparam int EXT_N  = 10;

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [15:0] src;
    logic [15:0] dst;
    logic [7:0]  cnt;
    logic [7:0]  reqs;
    logic [15:0] exp_src;
    logic [15:0] exp_dst;
    logic [7:0]  exp_cnt;
    logic        exp_en;
    logic [7:0]  exp_done;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{8'hD0, 16'h0010, 16'h0080, 8'd3, 8'd3, 16'h0016, 16'h0086, 8'd0, 1'b0, 8'd1},
    '{8'h70, 16'h0020, 16'h0090, 8'd4, 8'd4, 16'h0024, 16'h0090, 8'd0, 1'b0, 8'd1},
    '{8'hF1, 16'h0030, 16'h00A0, 8'd2, 8'd3, 16'h0031, 16'h00A1, 8'd1, 1'b1, 8'd1},
    '{8'h90, 16'h0040, 16'h00B0, 8'd2, 8'd1, 16'h0040, 16'h00B2, 8'd1, 1'b1, 8'd0},
    '{8'h11, 16'h0050, 16'h00C0, 8'd1, 8'd2, 16'h0050, 16'h00C0, 8'd1, 1'b1, 8'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic sw_start = 1'b0, ser0_txe = 1'b0, ser1_rx = 1'b0;
  logic [EXT_N-1:0] ext_evt = '0;
  logic mem_rd, mem_wr, mem_byte, done;
  logic [ADDR_W-1:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  int rd_cnt = 0;
  int done_cnt = 0;
  logic [7:0] mem [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .EXT_N(EXT_N)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .sw_start_i(sw_start), .ser0_txe_i(ser0_txe), .ser1_rx_i(ser1_rx), .ext_evt_i(ext_evt),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_byte_o(mem_byte), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .done_o(done)
  );

  // little-endian memory model, combinational read
  always_comb begin
    if (mem_byte) mem_rdata = {8'h00, mem[mem_addr[7:0]]};
    else          mem_rdata = {mem[mem_addr[7:0] + 8'd1], mem[mem_addr[7:0]]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
    end else if (mem_wr) begin
      mem[mem_addr[7:0]] <= mem_wdata[7:0];
      if (!mem_byte) mem[mem_addr[7:0] + 8'd1] <= mem_wdata[15:8];
    end
  end

  always_ff @(posedge clk) begin
    if (mem_rd) rd_cnt <= rd_cnt + 1;
    if (done) done_cnt <= done_cnt + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input int which, input int lane);
    @(negedge clk);
    case (which)
      0: sw_start = 1'b1;
      1: ser0_txe = 1'b1;
      2: ser1_rx  = 1'b1;
      3: ext_evt  = EXT_N'(1) << lane;
      default: ext_evt = '1;
    endcase
    @(negedge clk);
    sw_start = 1'b0; ser0_txe = 1'b0; ser1_rx = 1'b0; ext_evt = '0;
    repeat (5) @(negedge clk);
  endtask

  task automatic flag_is(input string req, input logic exp);
    logic [7:0] d;
    rd_reg(3'd0, d);
    check(req, 32'(d[1]), 32'(exp));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d, lo, hi;
    int rd0, dn0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd_reg(3'(a), d);
      check("R1 reg reset", 32'(d), 32'h0);
    end
    check("R1 outputs idle", {29'd0, mem_rd, mem_wr, done}, 32'h0);

    // R2 control byte 1 reserved nibble
    wr_reg(3'd1, 8'hFF);
    rd_reg(3'd1, d);
    check("R2 ctrl1 low nibble", 32'(d), 32'hF0);

    // R4 source selection, R3 flag write semantics (channel disabled)
    wr_reg(3'd0, 8'h04);
    pulse(0, 0);
    flag_is("R4 sw start ignored on code 01", 1'b0);
    pulse(1, 0);
    flag_is("R4 tx event on code 01", 1'b1);
    wr_reg(3'd0, 8'h06);
    flag_is("R3 write 1 keeps flag", 1'b1);
    wr_reg(3'd0, 8'h04);
    flag_is("R3 write 0 clears flag", 1'b0);
    pulse(2, 0);
    flag_is("R4 rx event ignored on code 01", 1'b0);
    wr_reg(3'd0, 8'h08);
    pulse(2, 0);
    flag_is("R4 rx event on code 10", 1'b1);
    wr_reg(3'd0, 8'h0C);
    wr_reg(3'd1, 8'h30);
    pulse(3, 2);
    flag_is("R4 ext lane 2 ignored on code 3", 1'b0);
    pulse(3, 3);
    flag_is("R4 ext lane 3 on code 3", 1'b1);
    wr_reg(3'd0, 8'h0C);
    wr_reg(3'd1, 8'h90);
    pulse(3, 9);
    flag_is("R4 ext lane 9 on code 9", 1'b1);
    wr_reg(3'd0, 8'h0C);
    wr_reg(3'd1, 8'hA0);
    pulse(4, 0);
    flag_is("R5 reserved code 10 silent", 1'b0);
    wr_reg(3'd1, 8'hF0);
    pulse(4, 0);
    flag_is("R5 reserved code 15 silent", 1'b0);

    // R6 pending request waits for enable
    wr_reg(3'd0, 8'h00);
    wr_reg(3'd2, 8'h60); wr_reg(3'd3, 8'h00);
    wr_reg(3'd4, 8'hD0); wr_reg(3'd5, 8'h00);
    wr_reg(3'd6, 8'h01);
    rd0 = rd_cnt; dn0 = done_cnt;
    pulse(0, 0);
    flag_is("R6 flag latched while disabled", 1'b1);
    check("R6 no read while disabled", 32'(rd_cnt - rd0), 32'd0);
    wr_reg(3'd0, 8'h12);
    repeat (6) @(negedge clk);
    check("R6 serviced after enable", 32'(rd_cnt - rd0), 32'd1);
    flag_is("R7 service clears flag", 1'b0);
    rd_reg(3'd0, d);
    check("R9 enable cleared at end", 32'(d[4]), 32'd0);
    check("R9 done pulsed once", 32'(done_cnt - dn0), 32'd1);
    check("R7 halfword copied", {16'd0, mem[8'hD1], mem[8'hD0]}, {16'd0, 8'h61 ^ 8'h5A, 8'h60 ^ 8'h5A});

    // vector table: R7 R8 R9 R10 R11
    for (int v = 0; v < NV; v++) begin
      wr_reg(3'd0, 8'h00);
      wr_reg(3'd2, VECS[v].src[7:0]); wr_reg(3'd3, VECS[v].src[15:8]);
      wr_reg(3'd4, VECS[v].dst[7:0]); wr_reg(3'd5, VECS[v].dst[15:8]);
      wr_reg(3'd6, VECS[v].cnt);
      rd0 = rd_cnt; dn0 = done_cnt;
      wr_reg(3'd0, VECS[v].ctrl);
      for (int r = 0; r < int'(VECS[v].reqs); r++) pulse(0, 0);
      rd_reg(3'd2, lo); rd_reg(3'd3, hi);
      check($sformatf("R8 R11 vec%0d source pointer", v), 32'({hi, lo}), 32'(VECS[v].exp_src));
      rd_reg(3'd4, lo); rd_reg(3'd5, hi);
      check($sformatf("R8 R10 vec%0d destination pointer", v), 32'({hi, lo}), 32'(VECS[v].exp_dst));
      rd_reg(3'd6, lo); rd_reg(3'd7, hi);
      check($sformatf("R9 R10 vec%0d count", v), 32'({hi, lo}), 32'(VECS[v].exp_cnt));
      rd_reg(3'd0, d);
      check($sformatf("R9 R10 vec%0d enable", v), 32'(d[4]), 32'(VECS[v].exp_en));
      check($sformatf("R9 R10 vec%0d done pulses", v), 32'(done_cnt - dn0), 32'(VECS[v].exp_done));
      check($sformatf("R7 vec%0d reads", v), 32'(rd_cnt - rd0), 32'(VECS[v].reqs));
    end

    // R7 R8 data landed where the steps say
    for (int i = 0; i < 6; i++)
      check("R7 halfword block copy", 32'(mem[8'h80 + 8'(i)]), 32'((8'h10 + 8'(i)) ^ 8'h5A));
    check("R8 fixed byte destination", 32'(mem[8'h90]), 32'(8'h23 ^ 8'h5A));
    check("R7 byte write leaves next byte", 32'(mem[8'h91]), 32'(8'h91 ^ 8'h5A));
    check("R10 ring rewrote first byte", 32'(mem[8'hA0]), 32'(8'h30 ^ 8'h5A));
    check("R8 fixed halfword source", 32'({mem[8'hB1], mem[8'hB0]}), 32'({8'h41 ^ 8'h5A, 8'h40 ^ 8'h5A}));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule